// File: doc/BRIEF.md
# Positional Slice Residue Reducer

This combinational unit takes one slice of a wide operand, knowing where that slice sits in the operand, and turns it into a narrow value that has the same remainder modulo a fixed modulus. The slice at position P carries the weight 2^((P+1)·W_BASE), because the least significant W_BASE bits of the operand form the base part and are not handled here. Several copies, one per slice position, run side by side. Their outputs are added together and corrected elsewhere to give the full remainder.

The slice is cut into fields of W_FIELD bits, starting from bit 0. Each field addresses its own constant table. Every field has its own copy of the table, so all lookups happen at the same time. Entry j of a table holds (j · 2^((P+1)·W_BASE)) mod MODULUS. The output of field k is shifted left by k·W_FIELD bits, and all fields are summed. Two fold steps follow. Each fold step takes the bits above W_BASE as an index into a second constant table whose entries are (idx · 2^W_BASE) mod MODULUS, drops those bits and adds the table entry. No step depends on a data-dependent loop, so the logic depth is fixed.

All tables are computed when the design is elaborated. The result fits in W_BASE bits and has the right remainder, but it is not always below MODULUS.

Top module: `stage_slice_reducer`

## Requirements
- R1: With the default parameters (W_BASE=4, W_SLICE=4, W_FIELD=2, MODULUS=14, position 0), part_res_out mod 14 equals (slice·2) mod 14 for every 4-bit slice, since 16 mod 14 = 2.
- R2: A slice of zero gives part_res_out equal to zero.
- R3: After the first fold, at most one bit remains above bit position W_BASE-1 of the running value.
- R4: After the second fold, no bit remains above bit position W_BASE-1, so the output keeps every significant bit.
- R5: The table constants follow the position parameter: with position 2 (shift 12, 2^12 mod 14 = 8), part_res_out mod 14 equals (slice·8) mod 14 for every slice.
- R6: A slice whose width is not a multiple of the field width is handled by padding the top field with zeros: with W_SLICE=5, W_FIELD=3, MODULUS=11 and position 1 (2^8 mod 11 = 3), part_res_out mod 11 equals (slice·3) mod 11 for all 32 slices.
- R7: The unit has no storage. The output follows a change of the slice within the same time step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slice_in | input | W_SLICE | Slice of the wide operand at position STAGE_POS |
| part_res_out | output | W_BASE | Partial residue congruent to slice_in·2^((STAGE_POS+1)·W_BASE) mod MODULUS |

## Verification
The checker assumes the parameters keep W_FIELD between half of W_SLICE and W_SLICE. It also assumes MODULUS lies in the upper half of the W_BASE range, above 2^(W_BASE-1) and below 2^W_BASE. Under these two conditions the fold-bound properties hold. The checker also only judges a settled slice value that contains no unknown bits. The stimulus stays inside these limits. Every instance in the bench uses a parameter set that meets both conditions. The bench drives each instance with every possible slice value, one at a time, and samples only after the combinational logic has settled.

// File: rtl/slice_fold_pkg.sv
package slice_fold_pkg;

    // (v * 2^sh) mod m, evaluated by repeated doubling so it never overflows
    function automatic longint shl_mod(longint v, int sh, longint m);
        longint r;
        r = v % m;
        for (int k = 0; k < sh; k++) begin
            r = (r * 2) % m;
        end
        return r;
    endfunction

    // number of W_FIELD-bit fields covering a W_SLICE-bit slice
    function automatic int field_count(int w_slice, int w_field);
        return (w_slice + w_field - 1) / w_field;
    endfunction

endpackage

// File: rtl/field_residue_lut.sv
module field_residue_lut #(
    parameter int W_BASE  = 4,
    parameter int W_FIELD = 2,
    parameter int MODULUS = 14,
    parameter int SHIFT   = 4
) (
    input  logic [W_FIELD-1:0] idx,
    output logic [W_BASE-1:0]  res
);
    localparam int DEPTH = 1 << W_FIELD;

    logic [W_BASE-1:0] tbl [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        assign tbl[e] = W_BASE'(slice_fold_pkg::shl_mod(longint'(e), SHIFT, longint'(MODULUS)));
    end

    assign res = tbl[idx];
endmodule

// File: rtl/slice_fold_step.sv
module slice_fold_step #(
    parameter int W_BASE  = 4,
    parameter int W_SUM   = 8,
    parameter int MODULUS = 14
) (
    input  logic [W_SUM-1:0] val_in,
    output logic [W_SUM-1:0] val_out
);
    localparam int W_HIGH = W_SUM - W_BASE;
    localparam int DEPTH  = 1 << W_HIGH;

    logic [W_BASE-1:0] tbl [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        assign tbl[e] = W_BASE'(slice_fold_pkg::shl_mod(longint'(e), W_BASE, longint'(MODULUS)));
    end

    assign val_out = W_SUM'(val_in[W_BASE-1:0]) + W_SUM'(tbl[val_in[W_SUM-1:W_BASE]]);
endmodule

// File: rtl/stage_slice_reducer.sv
module stage_slice_reducer #(
    parameter int W_BASE    = 4,
    parameter int W_SLICE   = 4,
    parameter int W_FIELD   = 2,
    parameter int MODULUS   = 14,
    parameter int STAGE_POS = 0
) (
    input  logic [W_SLICE-1:0] slice_in,
    output logic [W_BASE-1:0]  part_res_out
);
    localparam int NF    = slice_fold_pkg::field_count(W_SLICE, W_FIELD);
    localparam int W_PAD = NF * W_FIELD;
    localparam int W_SUM = W_BASE + (NF - 1) * W_FIELD + $clog2(NF + 1);
    localparam int W_OVF = W_SUM - W_BASE;
    localparam int SHIFT = (STAGE_POS + 1) * W_BASE;

    logic [W_PAD-1:0] padded;
    logic [W_SUM-1:0] weighted [NF];
    logic [W_SUM-1:0] raw_sum;
    logic [W_SUM-1:0] fold_one;
    logic [W_SUM-1:0] fold_two;
    logic [W_OVF-1:0] mid_ovf;
    logic [W_OVF-1:0] tail_ovf;

    assign padded = W_PAD'(slice_in);

    for (genvar k = 0; k < NF; k++) begin : g_field
        logic [W_BASE-1:0] f_res;
        field_residue_lut #(
            .W_BASE(W_BASE), .W_FIELD(W_FIELD), .MODULUS(MODULUS), .SHIFT(SHIFT)
        ) u_lut (
            .idx(padded[k*W_FIELD +: W_FIELD]),
            .res(f_res)
        );
        assign weighted[k] = W_SUM'(f_res) << (k * W_FIELD);
    end

    always_comb begin
        logic [W_SUM-1:0] acc;
        acc = '0;
        for (int k = 0; k < NF; k++) begin
            acc = acc + weighted[k];
        end
        raw_sum = acc;
    end

    slice_fold_step #(.W_BASE(W_BASE), .W_SUM(W_SUM), .MODULUS(MODULUS)) u_fold_a (
        .val_in(raw_sum), .val_out(fold_one)
    );
    slice_fold_step #(.W_BASE(W_BASE), .W_SUM(W_SUM), .MODULUS(MODULUS)) u_fold_b (
        .val_in(fold_one), .val_out(fold_two)
    );

    assign mid_ovf      = fold_one[W_SUM-1:W_BASE];
    assign tail_ovf     = fold_two[W_SUM-1:W_BASE];
    assign part_res_out = fold_two[W_BASE-1:0];
endmodule

// File: rtl/stage_slice_reducer_chk.sv
module stage_slice_reducer_chk #(
    parameter int W_BASE  = 4,
    parameter int W_SLICE = 4,
    parameter int W_OVF   = 4,
    parameter int MODULUS = 14,
    parameter int SHIFT   = 4
) (
    input logic [W_SLICE-1:0] slice_in,
    input logic [W_BASE-1:0]  part_res_out,
    input logic [W_OVF-1:0]   mid_ovf,
    input logic [W_OVF-1:0]   tail_ovf
);
    always_comb begin
        if (!$isunknown(slice_in)) begin
            // R1
            congruence_chk: assert ((longint'(part_res_out) % longint'(MODULUS)) ==
                slice_fold_pkg::shl_mod(longint'(slice_in), SHIFT, longint'(MODULUS)));
            // R2
            zero_slice_chk: assert (slice_in != '0 || part_res_out == '0);
            // R3
            first_fold_chk: assert ($countones(mid_ovf) <= 1 && mid_ovf <= W_OVF'(1));
            // R4
            no_overflow_chk: assert (tail_ovf == '0);
        end
    end
endmodule

bind stage_slice_reducer stage_slice_reducer_chk #(
    .W_BASE(W_BASE), .W_SLICE(W_SLICE), .W_OVF(W_OVF), .MODULUS(MODULUS), .SHIFT(SHIFT)
) u_chk (
    .slice_in(slice_in),
    .part_res_out(part_res_out),
    .mid_ovf(mid_ovf),
    .tail_ovf(tail_ovf)
);

// File: tb/stage_slice_reducer_test.sv
module stage_slice_reducer_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [3:0] s_def;
    logic [3:0] r_def;
    logic [3:0] s_pos;
    logic [3:0] r_pos;
    logic [4:0] s_odd;
    logic [3:0] r_odd;

    stage_slice_reducer uut (.slice_in(s_def), .part_res_out(r_def));

    stage_slice_reducer #(.STAGE_POS(2)) u_pos (.slice_in(s_pos), .part_res_out(r_pos));

    stage_slice_reducer #(
        .W_BASE(4), .W_SLICE(5), .W_FIELD(3), .MODULUS(11), .STAGE_POS(1)
    ) u_odd (.slice_in(s_odd), .part_res_out(r_odd));

    // expected residue mod 14 of slice*16 (position 0), indexed by slice
    localparam logic [7:0] VEC [16] = '{
        8'd0, 8'd2, 8'd4, 8'd6, 8'd8, 8'd10, 8'd12, 8'd0,
        8'd2, 8'd4, 8'd6, 8'd8, 8'd10, 8'd12, 8'd0, 8'd2
    };

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        s_def = '0; s_pos = '0; s_odd = '0;
        @(negedge clk);
        // R2: zero slices give zero
        check("R2 default zero", r_def, 0);
        check("R2 pos2 zero", r_pos, 0);
        check("R2 odd zero", r_odd, 0);

        // R1: vector table walk
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            s_def = 4'(s);
            #1;
            check($sformatf("R1 slice=%0d", s), longint'(r_def) % 14, longint'(VEC[s]));
        end

        // R5: position 2, constant 8
        for (int s = 0; s < 16; s++) begin
            @(negedge clk);
            s_pos = 4'(s);
            #1;
            check($sformatf("R5 slice=%0d", s), longint'(r_pos) % 14, (s * 8) % 14);
        end

        // R6: 5-bit slice, 3-bit fields, constant 3 mod 11
        for (int s = 0; s < 32; s++) begin
            @(negedge clk);
            s_odd = 5'(s);
            #1;
            check($sformatf("R6 slice=%0d", s), longint'(r_odd) % 11, (s * 3) % 11);
        end

        // R1 corner: all-ones slice
        @(negedge clk);
        s_def = 4'hF;
        #1;
        check("R1 all ones", longint'(r_def) % 14, 2);

        // R7: output follows input between clock edges
        @(posedge clk);
        #1;
        s_def = 4'd3;
        #1;
        check("R7 same step a", longint'(r_def) % 14, 6);
        s_def = 4'd5;
        #1;
        check("R7 same step b", longint'(r_def) % 14, 10);
        s_def = 4'd0;
        #1;
        check("R2 back to zero", r_def, 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule